// File: doc/BRIEF.md
# Delayed Coincidence Window Matcher

This block pairs each reference pulse with a partner pulse that is expected a programmable number of clock cycles later. Each reference event waits a delay of N cycles and then opens a window of W cycles. The first partner pulse that falls inside a window is credited to that event, and the block reports the position of the hit within the window. An event whose window runs out with no partner produces a one-cycle miss pulse. The usual setting centres the expected partner arrival in the window, for example a delay of 8 with a width of 3.

Several reference events can be in flight at once, including on consecutive cycles. Each one keeps its own window. A partner pulse never serves more than one event, and it always goes to the oldest window that is open. One instance serves one signal pair. Parameters set the reset configuration, so each pair can start from its own delay and width.

Top module: `coinc_window`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `matchValid` and `missPulse` are low and no reference event is pending.
- R2: Take a reference pulse sampled at clock edge e. If a partner pulse is sampled at edge e+N+s, with 0 <= s <= W-1, the event is matched. `matchValid` is then high for the cycle after that edge, and `matchSlot` equals s.
- R3: With a delay of 0, a partner pulse sampled at the same edge as the reference pulse counts as slot 0.
- R4: When several windows are open, one partner pulse is credited only to the oldest of them. The younger windows stay open and can still be matched later.
- R5: Consider an event that reaches the last slot of its window, edge e+N+W-1, with no partner credited to it. `missPulse` is high for the cycle after that edge, and the event is dropped.
- R6: A partner pulse sampled when no window is open has no effect: no match, and no change to later results.
- R7: A width setting of 0 behaves exactly like a width of 1.
- R8: At an edge where `cfgDelay` or `cfgWidth` differs from its value at the previous edge, all pending events and the reference pulse of that edge are discarded. No match or miss is reported for that edge, and none is reported later for the discarded events.
- R9: The full range works: a delay of 255 with a width of 15 places slot 14 at edge e+269.
- R10: `matchValid` and `missPulse` are never high in the same cycle, and `matchSlot` is always below the effective width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per crossing |
| rstN | input | 1 | Asynchronous active-low reset |
| refPulse | input | 1 | Reference event, one event per high cycle |
| partnerPulse | input | 1 | Partner event to be matched |
| cfgDelay | input | 8 | Delay N in cycles from reference to slot 0 |
| cfgWidth | input | 4 | Window width W in cycles (0 acts as 1) |
| matchValid | output | 1 | One-cycle flag: a pending event was matched |
| matchSlot | output | 4 | Slot offset of the match inside the window |
| missPulse | output | 1 | One-cycle flag: a window closed unmatched |

## Verification
The bench aims at the cases where per-event tracking differs from a plain AND gate. A burst of back-to-back references served by a single partner shows whether a design credits the youngest window, or several windows at once, instead of only the oldest. A design that is off by one in slot position or miss timing is caught by a partner at slot W-1 and by the zero-delay, same-edge case; either one would shift or lose the match. Changing the configuration while windows are pending, then sending the partner where the old window would have been, exposes a design that lets stale events match or report misses. The 255/15 extreme exposes age storage that is too short.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  // Strobes from the control half to the tracking datapath.
  typedef struct packed {
    logic clearAll;   // drop every pending event this edge
    logic acceptRef;  // the reference pulse of this edge may be stored
  } coincStrobes_t;
endpackage

// File: rtl/coinc_ctrl.sv
module coinc_ctrl
  import coinc_pkg::*;
#(
  parameter int DELAY_W   = 8,
  parameter int WIDTH_W   = 4,
  parameter int DEF_DELAY = 8,
  parameter int DEF_WIDTH = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DELAY_W-1:0] cfgDelay,
  input  logic [WIDTH_W-1:0] cfgWidth,
  output coincStrobes_t      strobes,
  output logic [DELAY_W-1:0] activeDelay,
  output logic [WIDTH_W-1:0] activeWidth
);
  logic [DELAY_W-1:0] heldDelay;
  logic [WIDTH_W-1:0] heldWidth;
  logic               cfgChanged;

  assign cfgChanged = (cfgDelay != heldDelay) || (cfgWidth != heldWidth);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldDelay <= DELAY_W'(DEF_DELAY);
      heldWidth <= WIDTH_W'(DEF_WIDTH);
    end else begin
      heldDelay <= cfgDelay;
      heldWidth <= cfgWidth;
    end
  end

  always_comb begin
    strobes.clearAll  = cfgChanged;
    strobes.acceptRef = !cfgChanged;
    activeDelay       = heldDelay;
    activeWidth       = (heldWidth == '0) ? WIDTH_W'(1) : heldWidth;
  end
endmodule

// File: rtl/coinc_track.sv
module coinc_track
  import coinc_pkg::*;
#(
  parameter int DELAY_W = 8,
  parameter int WIDTH_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  coincStrobes_t      strobes,
  input  logic               refPulse,
  input  logic               partnerPulse,
  input  logic [DELAY_W-1:0] activeDelay,
  input  logic [WIDTH_W-1:0] activeWidth,
  output logic               matchValid,
  output logic [WIDTH_W-1:0] matchSlot,
  output logic               missPulse
);
  localparam int MAX_AGE = (1 << DELAY_W) - 1 + (1 << WIDTH_W) - 2;
  localparam int AGE_W   = $clog2(MAX_AGE + 1);

  // pendAge[a] set: an event referenced a edges ago is still open.
  logic [MAX_AGE:1] pendAge;
  logic [MAX_AGE:0] curAge, inWin, hitAge, clrAge, keepAge;
  logic [AGE_W-1:0] lastAge, oldestAge, delayExt;
  logic             foundHit, missNow;

  assign delayExt = AGE_W'(activeDelay);
  assign lastAge  = delayExt + AGE_W'(activeWidth) - AGE_W'(1);

  always_comb begin
    curAge    = {pendAge, refPulse & strobes.acceptRef};
    foundHit  = 1'b0;
    oldestAge = '0;
    for (int a = 0; a <= MAX_AGE; a++) begin
      inWin[a]  = (AGE_W'(a) >= delayExt) && (AGE_W'(a) <= lastAge);
      hitAge[a] = curAge[a] & inWin[a] & partnerPulse;
      if (hitAge[a]) begin
        foundHit  = 1'b1;
        oldestAge = AGE_W'(a);
      end
    end
    for (int a = 0; a <= MAX_AGE; a++) begin
      clrAge[a]  = foundHit && (oldestAge == AGE_W'(a));
      keepAge[a] = curAge[a] & ~clrAge[a] & (AGE_W'(a) < lastAge);
    end
    missNow = curAge[lastAge] & ~clrAge[lastAge];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAge    <= '0;
      matchValid <= 1'b0;
      matchSlot  <= '0;
      missPulse  <= 1'b0;
    end else if (strobes.clearAll) begin
      pendAge    <= '0;
      matchValid <= 1'b0;
      matchSlot  <= '0;
      missPulse  <= 1'b0;
    end else begin
      pendAge    <= keepAge[MAX_AGE-1:0];
      matchValid <= foundHit;
      matchSlot  <= foundHit ? WIDTH_W'(oldestAge - delayExt) : '0;
      missPulse  <= missNow;
    end
  end
endmodule

// File: rtl/coinc_window.sv
module coinc_window
  import coinc_pkg::*;
#(
  parameter int DELAY_W   = 8,
  parameter int WIDTH_W   = 4,
  parameter int DEF_DELAY = 8,
  parameter int DEF_WIDTH = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refPulse,
  input  logic               partnerPulse,
  input  logic [DELAY_W-1:0] cfgDelay,
  input  logic [WIDTH_W-1:0] cfgWidth,
  output logic               matchValid,
  output logic [WIDTH_W-1:0] matchSlot,
  output logic               missPulse
);
  coincStrobes_t      strobes;
  logic [DELAY_W-1:0] activeDelay;
  logic [WIDTH_W-1:0] activeWidth;

  coinc_ctrl #(
    .DELAY_W(DELAY_W), .WIDTH_W(WIDTH_W),
    .DEF_DELAY(DEF_DELAY), .DEF_WIDTH(DEF_WIDTH)
  ) ctrlInst (
    .clk(clk), .rstN(rstN), .cfgDelay(cfgDelay), .cfgWidth(cfgWidth),
    .strobes(strobes), .activeDelay(activeDelay), .activeWidth(activeWidth)
  );

  coinc_track #(.DELAY_W(DELAY_W), .WIDTH_W(WIDTH_W)) trackInst (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .refPulse(refPulse), .partnerPulse(partnerPulse),
    .activeDelay(activeDelay), .activeWidth(activeWidth),
    .matchValid(matchValid), .matchSlot(matchSlot), .missPulse(missPulse)
  );
endmodule

// File: rtl/coinc_window_chk.sv
module coinc_window_chk #(
  parameter int DELAY_W = 8,
  parameter int WIDTH_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               partnerPulse,
  input logic [DELAY_W-1:0] cfgDelay,
  input logic [WIDTH_W-1:0] cfgWidth,
  input logic               matchValid,
  input logic [WIDTH_W-1:0] matchSlot,
  input logic               missPulse
);
  logic [WIDTH_W-1:0] slotLimit;
  assign slotLimit = (cfgWidth == '0) ? '0 : cfgWidth - WIDTH_W'(1);

  // R10
  match_miss_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(matchValid && missPulse));

  // R10
  slot_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |-> (matchSlot <= $past(slotLimit)));

  // R6
  no_partner_no_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    !partnerPulse |=> !matchValid);

  // R8
  cfg_change_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDelay != $past(cfgDelay) || cfgWidth != $past(cfgWidth))
      |=> (!matchValid && !missPulse));
endmodule

bind coinc_window coinc_window_chk #(.DELAY_W(DELAY_W), .WIDTH_W(WIDTH_W)) chkInst (
  .clk(clk), .rstN(rstN), .partnerPulse(partnerPulse),
  .cfgDelay(cfgDelay), .cfgWidth(cfgWidth),
  .matchValid(matchValid), .matchSlot(matchSlot), .missPulse(missPulse)
);

// File: tb/coinc_window_test.sv
module coinc_window_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refPulse = 1'b0, partnerPulse = 1'b0;
  logic [7:0] cfgDelay = 8'd8;
  logic [3:0] cfgWidth = 4'd3;
  logic       matchValid, missPulse;
  logic [3:0] matchSlot;

  int checks = 0, failures = 0;
  int cyc = 0;
  int evQ[$];
  int prevDelay = 8, prevWidth = 3;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  coinc_window uut (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .partnerPulse(partnerPulse),
    .cfgDelay(cfgDelay), .cfgWidth(cfgWidth),
    .matchValid(matchValid), .matchSlot(matchSlot), .missPulse(missPulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int effWidth(input int w);
    return (w == 0) ? 1 : w;
  endfunction

  // One clock: drive at the falling edge, predict, check after the rising edge.
  task automatic step(input bit r, input bit p, input int d, input int w, input string req);
    bit expMatch = 0, expMiss = 0;
    int expSlot = 0;
    refPulse = r; partnerPulse = p;
    cfgDelay = 8'(d); cfgWidth = 4'(w);
    if (d != prevDelay || w != prevWidth) begin
      evQ.delete();
    end else begin
      int lastA = d + effWidth(w) - 1;
      if (r) evQ.push_back(cyc);
      if (p) begin
        for (int i = 0; i < evQ.size(); i++) begin
          int age = cyc - evQ[i];
          if (age >= d && age <= lastA) begin
            expMatch = 1; expSlot = age - d; evQ.delete(i); break;
          end
        end
      end
      if (!expMatch && evQ.size() > 0 && (cyc - evQ[0]) == lastA) begin
        expMiss = 1; evQ.delete(0);
      end
    end
    prevDelay = d; prevWidth = w;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    chk(matchValid == expMatch, {req, " matchValid"}, int'(matchValid), int'(expMatch));
    chk(missPulse == expMiss, {req, " missPulse"}, int'(missPulse), int'(expMiss));
    if (expMatch)
      chk(int'(matchSlot) == expSlot, {req, " matchSlot"}, int'(matchSlot), expSlot);
  endtask

  task automatic idle(input int n, input int d, input int w, input string req);
    for (int i = 0; i < n; i++) step(0, 0, d, w, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: outputs quiet under reset and just after release
    repeat (3) @(negedge clk);
    chk(!matchValid && !missPulse, "R1 in reset", int'(matchValid | missPulse), 0);
    rstN = 1'b1;
    step(0, 1, 8, 3, "R1");
    // R2: delay 8, width 3, partner at slot 1
    step(1, 0, 8, 3, "R2"); idle(8, 8, 3, "R2"); step(0, 1, 8, 3, "R2"); idle(3, 8, 3, "R2");
    // R2: partner at last slot
    step(1, 0, 8, 3, "R2"); idle(9, 8, 3, "R2"); step(0, 1, 8, 3, "R2"); idle(2, 8, 3, "R2");
    // R5: no partner gives one miss
    step(1, 0, 8, 3, "R5"); idle(12, 8, 3, "R5");
    // R6: stray partners
    for (int i = 0; i < 5; i++) step(0, 1, 8, 3, "R6");
    // R8: change config with an event pending, partner where old window was
    step(1, 0, 8, 3, "R8"); idle(3, 8, 3, "R8");
    step(0, 0, 20, 3, "R8"); idle(4, 20, 3, "R8"); step(0, 1, 20, 3, "R8"); idle(25, 20, 3, "R8");
    // R3: zero delay, same-edge partner
    step(0, 0, 0, 2, "R3"); step(1, 1, 0, 2, "R3"); step(1, 0, 0, 2, "R3"); step(0, 1, 0, 2, "R3");
    idle(3, 0, 2, "R3");
    // R4: back-to-back references, single partner serves oldest only
    step(0, 0, 4, 3, "R4");
    step(1, 0, 4, 3, "R4"); step(1, 0, 4, 3, "R4"); step(1, 0, 4, 3, "R4");
    idle(3, 4, 3, "R4"); step(0, 1, 4, 3, "R4"); step(0, 0, 4, 3, "R4");
    step(0, 1, 4, 3, "R4"); idle(6, 4, 3, "R4");
    // R7: width 0 behaves as width 1
    step(0, 0, 5, 0, "R7"); step(1, 0, 5, 0, "R7"); idle(4, 5, 0, "R7"); step(0, 1, 5, 0, "R7");
    step(1, 0, 5, 0, "R7"); idle(7, 5, 0, "R7");
    // R9: delay 255, width 15, slot 14 and a miss
    step(0, 0, 255, 15, "R9"); step(1, 0, 255, 15, "R9"); step(1, 0, 255, 15, "R9");
    idle(267, 255, 15, "R9"); step(0, 1, 255, 15, "R9"); idle(4, 255, 15, "R9");
    // Random mix over the standard delays
    begin
      int dl = 8, wd = 3;
      int picks[8] = '{0, 4, 8, 21, 24, 116, 128, 37};
      for (int n = 0; n < 4000; n++) begin
        if (n % 400 == 0) begin
          dl = picks[$urandom % 8];
          if (dl == 37) dl = int'($urandom % 256);
          wd = int'($urandom % 16);
        end
        step(($urandom % 4) == 0, ($urandom % 3) == 0, dl, wd, "R2/R4/R5 random");
      end
      idle(300, dl, wd, "R5 drain");
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule